// File: doc/BRIEF.md
# Stereo Audio Serializer

This block sends two-channel PCM audio out on a single serial data line. A sample pair (left and right word) arrives on a valid/ready input and waits in a one-pair holding register. At the start of each frame the pair moves into the active registers. The block then emits one bit per bit-clock slot, most significant bit first: first the left word in the first half of the frame, then the right word in the second half.

The surrounding logic owns all clock generation. It supplies a single-cycle bit tick for every bit-clock period and marks the first slot of each frame with a frame-start strobe. Runtime inputs select the following:

- the word length: 16, 24 or 32 bits, taken from the low bits of each sample input;
- the length of a frame half: 16, 32 or 64 slots;
- where the word sits inside its half: one slot after the half boundary, on the boundary itself, or ending on the last slot of the half.

Slots that the word does not cover carry zero. A group of enable bits gates the whole transmit path.

Top module: `stereo_serializer`

## Requirements
- R1: The word-length code selects the word size: 0 gives 16 bits, 1 gives 24 bits, and 2 or 3 give 32 bits. The word is the low bits of the sample input and goes out MSB first. Input bits above the word have no effect.
- R2: The half-length code selects H: 0 gives 16 slots, 1 gives 32 slots, and 2 or 3 give 64 slots. Slots 0 to H-1 of a frame carry the left word, and slots H to 2H-1 carry the right word.
- R3: With `delayOne` high and `rightJust` low, the word MSB occupies slot 1 of its half, and slot 0 of the half is zero.
- R4: With `delayOne` low and `rightJust` low, the word MSB occupies slot 0 of its half.
- R5: With `rightJust` high, the word LSB occupies the last slot of its half, whatever `delayOne` is. If the word is longer than the half, the word starts at slot 0.
- R6: Slots outside the word are zero. Word bits that would fall past the end of a half are dropped.
- R7: In a cycle with `bitTick` high, `sdata` takes the bit for the current slot on that clock edge. Between ticks `sdata` holds its value. The current slot is 0 when `frameStart` is high together with `bitTick`; otherwise it is the previous slot plus one, wrapping from 2H-1 to 0.
- R8: `inReady` is high exactly when the holding register is empty. A pair is accepted in a cycle with `inValid` and `inReady` both high. The pair moves to the active registers at the next enabled frame start, which empties the holding register.
- R9: If the holding register is empty at an enabled frame start, both words of that frame are zero and `underrun` is high for the single following cycle. A pair accepted in that same cycle counts as not yet held.
- R10: When every bit of `txEn` is clear, `sdata` is zero from the next cycle on. In that state no pair is consumed and no underrun is raised. Any single set bit enables transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe per bit-clock period |
| frameStart | input | 1 | Marks slot 0 of a frame; meaningful only together with bitTick |
| txEn | input | EN_BITS | Transmit enables; all clear forces idle |
| wordLen | input | 2 | Word-length code |
| halfLen | input | 2 | Frame-half length code |
| delayOne | input | 1 | One-slot delay of the word after the half boundary |
| rightJust | input | 1 | Place the word at the end of the half |
| inValid | input | 1 | Sample pair offered |
| inLeft | input | 32 | Left sample, word in the low bits |
| inRight | input | 32 | Right sample, word in the low bits |
| inReady | output | 1 | Holding register empty |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse after a frame started with no pair held |

## Verification
The assertions assume that `frameStart` is high only in cycles that also carry `bitTick`. They also assume that two enabled frame starts never fall on consecutive clock cycles, because the single-pulse underrun property relies on it. The bench keeps to both conditions: it raises `frameStart` only on the first tick of a frame, and it separates every tick by an idle cycle. The bench changes the format codes only between frames, so the slot counter never sees a change of half length in the middle of a frame.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Frame slots go up to 2*64, so the slot position needs 7 bits.
  localparam int POS_W  = 7;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 1 << IDX_W;

  typedef struct packed {
    logic             shift;     // enabled bit tick
    logic             load;      // enabled frame start
    logic             rightHalf; // current slot lies in second half
    logic             dataOn;    // current slot carries a word bit
    logic [POS_W-1:0] bitIdx;    // word bit for the current slot
  } strobe_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       frameStart,
  input  logic       txOn,
  input  logic [1:0] wordLen,
  input  logic [1:0] halfLen,
  input  logic       delayOne,
  input  logic       rightJust,
  output strobe_t    strobe
);
  logic [POS_W-1:0] pos, posNow, lastPos, halfBits, wordBits;
  logic [POS_W-1:0] slotInHalf, startOff, wordPos;
  logic             inRight;

  always_comb begin
    case (halfLen)
      2'd0:    begin halfBits = POS_W'(16); lastPos = POS_W'(31);  end
      2'd1:    begin halfBits = POS_W'(32); lastPos = POS_W'(63);  end
      default: begin halfBits = POS_W'(64); lastPos = POS_W'(127); end
    endcase
    case (wordLen)
      2'd0:    wordBits = POS_W'(16);
      2'd1:    wordBits = POS_W'(24);
      default: wordBits = POS_W'(32);
    endcase

    if (frameStart)          posNow = '0;
    else if (pos >= lastPos) posNow = '0;
    else                     posNow = pos + POS_W'(1);

    inRight    = (posNow >= halfBits);
    slotInHalf = inRight ? (posNow - halfBits) : posNow;

    if (rightJust)
      startOff = (halfBits > wordBits) ? (halfBits - wordBits) : '0;
    else
      startOff = delayOne ? POS_W'(1) : '0;

    wordPos = slotInHalf - startOff;

    strobe.shift     = bitTick & txOn;
    strobe.load      = bitTick & frameStart & txOn;
    strobe.rightHalf = inRight;
    strobe.dataOn    = (slotInHalf >= startOff) && (wordPos < wordBits);
    strobe.bitIdx    = wordBits - POS_W'(1) - wordPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        pos <= '0;
    else if (bitTick) pos <= posNow;
  end
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              txOn,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  output logic              inReady,
  output logic              sdata,
  output logic              underrun
);
  logic              holdValid;
  logic [DATA_W-1:0] holdL, holdR, actL, actR;
  logic [DATA_W-1:0] leftWord, curWord;
  logic              pickBit;

  assign inReady = !holdValid;

  always_comb begin
    leftWord = strobe.load ? (holdValid ? holdL : '0) : actL;
    curWord  = strobe.rightHalf ? actR : leftWord;
    pickBit  = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (strobe.bitIdx == POS_W'(i)) pickBit = curWord[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdL     <= '0;
      holdR     <= '0;
      actL      <= '0;
      actR      <= '0;
      underrun  <= 1'b0;
      sdata     <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (strobe.load) begin
        actL     <= holdValid ? holdL : '0;
        actR     <= holdValid ? holdR : '0;
        underrun <= !holdValid;
        if (holdValid) holdValid <= 1'b0;
      end
      if (inValid && inReady) begin
        holdL     <= inLeft;
        holdR     <= inRight;
        holdValid <= 1'b1;
      end
      if (!txOn)             sdata <= 1'b0;
      else if (strobe.shift) sdata <= strobe.dataOn & pickBit;
    end
  end
endmodule

// File: rtl/stereo_serializer.sv
module stereo_serializer
  import ser_pkg::*;
#(
  parameter int EN_BITS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic               frameStart,
  input  logic [EN_BITS-1:0] txEn,
  input  logic [1:0]         wordLen,
  input  logic [1:0]         halfLen,
  input  logic               delayOne,
  input  logic               rightJust,
  input  logic               inValid,
  input  logic [31:0]        inLeft,
  input  logic [31:0]        inRight,
  output logic               inReady,
  output logic               sdata,
  output logic               underrun
);
  strobe_t strobe;
  logic    txOn;

  assign txOn = |txEn;

  ser_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameStart(frameStart),
    .txOn(txOn), .wordLen(wordLen), .halfLen(halfLen),
    .delayOne(delayOne), .rightJust(rightJust), .strobe(strobe)
  );

  ser_datapath u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txOn(txOn),
    .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .inReady(inReady), .sdata(sdata), .underrun(underrun)
  );
endmodule

// File: rtl/stereo_serializer_chk.sv
module stereo_serializer_chk #(
  parameter int EN_BITS = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               bitTick,
  input logic               frameStart,
  input logic [EN_BITS-1:0] txEn,
  input logic               inValid,
  input logic               inReady,
  input logic               sdata,
  input logic               underrun
);
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(|txEn) |=> !sdata);

  assert_idle_no_underrun_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(|txEn) |=> !underrun);

  assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && (|txEn)) |=> $stable(sdata));

  assert_accept_fills_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  assert_load_frees_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && frameStart && (|txEn) && !inReady) |=> inReady);

  assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(bitTick && frameStart && (|txEn) && inReady));

  assert_underrun_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);
endmodule

bind stereo_serializer stereo_serializer_chk #(.EN_BITS(EN_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameStart(frameStart),
  .txEn(txEn), .inValid(inValid), .inReady(inReady), .sdata(sdata),
  .underrun(underrun)
);

// File: tb/test_stereo_serializer.sv
`timescale 1ns/1ps
module test_stereo_serializer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0, frameStart = 1'b0;
  logic [2:0]  txEn = 3'b001;
  logic [1:0]  wordLen = 2'd0, halfLen = 2'd0;
  logic        delayOne = 1'b0, rightJust = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inLeft = '0, inRight = '0;
  logic        inReady, sdata, underrun;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stereo_serializer #(.EN_BITS(3)) i_stereo_serializer (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameStart(frameStart),
    .txEn(txEn), .wordLen(wordLen), .halfLen(halfLen), .delayOne(delayOne),
    .rightJust(rightJust), .inValid(inValid), .inLeft(inLeft),
    .inRight(inRight), .inReady(inReady), .sdata(sdata), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wBits();
    return (wordLen == 2'd0) ? 16 : (wordLen == 2'd1) ? 24 : 32;
  endfunction
  function automatic int hBits();
    return (halfLen == 2'd0) ? 16 : (halfLen == 2'd1) ? 32 : 64;
  endfunction

  // Expected serial bit for frame slot p, built from R1..R6 placement rules.
  function automatic logic expBit(input int p, input logic [31:0] l,
                                  input logic [31:0] r);
    int w = wBits();
    int h = hBits();
    int q = p % h;
    logic [31:0] word = (p < h) ? l : r;
    int first;
    if (rightJust) first = (h > w) ? h - w : 0;
    else           first = delayOne ? 1 : 0;
    for (int i = 0; i < w; i++)
      if (first + i == q) return word[w-1-i];
    return 1'b0;
  endfunction

  task automatic pushPair(input logic [31:0] l, input logic [31:0] r);
    inValid = 1'b1; inLeft = l; inRight = r;
    while (!inReady) begin @(posedge clk); @(negedge clk); end
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
  endtask

  // One frame: a tick each slot followed by an idle cycle. Two samples per slot.
  task automatic runFrame(input logic [31:0] l, input logic [31:0] r,
                          input bit useFs, input bit expUnder, input string req);
    for (int p = 0; p < 2 * hBits(); p++) begin
      logic e;
      e = expBit(p, l, r);
      bitTick = 1'b1; frameStart = useFs && (p == 0);
      @(posedge clk); @(negedge clk);
      bitTick = 1'b0; frameStart = 1'b0;
      check(sdata === e, req, {31'd0, sdata}, {31'd0, e});
      if (p == 0) check(underrun === expUnder, "R9", {31'd0, underrun}, {31'd0, expUnder});
      @(posedge clk); @(negedge clk);
      check(sdata === e, "R7", {31'd0, sdata}, {31'd0, e});
      if (p == 0) check(underrun === 1'b0, "R9", {31'd0, underrun}, 32'd0);
    end
  endtask

  task automatic t_reset();
    check(sdata === 1'b0, "R7 reset sdata", {31'd0, sdata}, 32'd0);
    check(underrun === 1'b0, "R9 reset underrun", {31'd0, underrun}, 32'd0);
    check(inReady === 1'b1, "R8 reset ready", {31'd0, inReady}, 32'd1);
  endtask

  task automatic t_standard();
    wordLen = 2'd0; halfLen = 2'd1; delayOne = 1'b1; rightJust = 1'b0;
    pushPair(32'h0000A5C3, 32'h00003C5A);
    check(inReady === 1'b0, "R8 held", {31'd0, inReady}, 32'd0);
    runFrame(32'h0000A5C3, 32'h00003C5A, 1'b1, 1'b0, "R3");
    check(inReady === 1'b1, "R8 freed", {31'd0, inReady}, 32'd1);
    // No frameStart: slot counter wraps and the same active pair repeats (R7).
    runFrame(32'h0000A5C3, 32'h00003C5A, 1'b0, 1'b0, "R7 wrap");
  endtask

  task automatic t_leftjust();
    wordLen = 2'd1; halfLen = 2'd1; delayOne = 1'b0; rightJust = 1'b0;
    pushPair(32'hFF9E3467, 32'hAB81C2F5);   // upper bytes must not appear (R1)
    runFrame(32'h009E3467, 32'h0081C2F5, 1'b1, 1'b0, "R4 R1");
  endtask

  task automatic t_rightjust();
    wordLen = 2'd1; halfLen = 2'd1; delayOne = 1'b0; rightJust = 1'b1;
    pushPair(32'h00C0FFEE, 32'h00812345);
    runFrame(32'h00C0FFEE, 32'h00812345, 1'b1, 1'b0, "R5");
    wordLen = 2'd0; halfLen = 2'd2; delayOne = 1'b1; rightJust = 1'b1;
    pushPair(32'h0000B00F, 32'h00007E81);
    runFrame(32'h0000B00F, 32'h00007E81, 1'b1, 1'b0, "R5 R2");
  endtask

  task automatic t_full32();
    wordLen = 2'd2; halfLen = 2'd1; delayOne = 1'b0; rightJust = 1'b0;
    pushPair(32'h8F00F0F1, 32'h13579BDF);
    runFrame(32'h8F00F0F1, 32'h13579BDF, 1'b1, 1'b0, "R1 R2");
    halfLen = 2'd0;   // word longer than half: tail dropped (R6)
    pushPair(32'hC3A50F96, 32'h6E01F7B2);
    runFrame(32'hC3A50F96, 32'h6E01F7B2, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_underrun();
    wordLen = 2'd0; halfLen = 2'd0; delayOne = 1'b0; rightJust = 1'b0;
    runFrame(32'h0, 32'h0, 1'b1, 1'b1, "R9 zeros");
    check(inReady === 1'b1, "R9 ready", {31'd0, inReady}, 32'd1);
  endtask

  task automatic t_backpressure();
    wordLen = 2'd0; halfLen = 2'd0; delayOne = 1'b1; rightJust = 1'b0;
    pushPair(32'h0000F00D, 32'h0000BEEF);
    inValid = 1'b1; inLeft = 32'h00001111; inRight = 32'h00002222;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check(inReady === 1'b0, "R8 backpressure", {31'd0, inReady}, 32'd0);
    end
    inValid = 1'b0;
    runFrame(32'h0000F00D, 32'h0000BEEF, 1'b1, 1'b0, "R8 first pair");
    runFrame(32'h0, 32'h0, 1'b1, 1'b1, "R8 refused pair dropped");
  endtask

  task automatic t_disable();
    wordLen = 2'd0; halfLen = 2'd0; delayOne = 1'b0; rightJust = 1'b0;
    txEn = 3'b000;
    pushPair(32'h0000FFFF, 32'h0000FFFF);
    runFrame(32'h0, 32'h0, 1'b1, 1'b0, "R10 idle");
    check(inReady === 1'b0, "R10 pair kept", {31'd0, inReady}, 32'd0);
    txEn = 3'b100;
    runFrame(32'h0000FFFF, 32'h0000FFFF, 1'b1, 1'b0, "R10 enabled");
    txEn = 3'b001;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_standard();
    t_leftjust();
    t_rightjust();
    t_full32();
    t_underrun();
    t_backpressure();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule